// File: doc/BRIEF.md
# Hash Message Block Formatter

The formatter sits between a multithreaded issuing processor and a small group of hash cores. The processor queues requests. Each request names a thread, a start offset and a byte length inside that thread's private data memory. It also carries two flags: one opens a new message context and one closes it. For each request the formatter reads the bytes one at a time and appends them to the thread's pending 64-byte block. Each time a block fills, the formatter writes the block to a core as sixteen 32-bit words.

When a request closes its context, the formatter terminates the message with the usual hash padding. This is a 0x80 byte, then zero bytes, then the message length in bits as a 64-bit big-endian number in the last eight bytes. If the marker and the length do not fit together, the padding takes two blocks. Each thread keeps its own pending block, byte count and running total. Requests from different threads can therefore interleave freely, and a later request continues where an earlier one stopped.

Blocks go to the cores in strict rotation. Each block carries a flag that tells the receiving core whether to start from the standard initial hash values or to chain from the digest it already holds. The formatter runs a five-state machine:

- IDLE accepts a request and, when the open flag is set, clears the thread's context. It then goes to READ.
- READ issues one memory read and goes to WRITE. When no bytes remain, READ instead goes to WAIT if the close flag is set, or back to IDLE if it is not.
- WRITE appends the returned byte. It goes to WAIT when the block is now full, otherwise back to READ.
- WAIT holds until the target core has room, then goes to EMIT.
- EMIT sends sixteen words. It then goes back to READ after a data block, to WAIT after a marker-only padding block, or to IDLE after the length block.

Top module: `hash_block_formatter`

## Requirements
- R1: After reset, `req_ready` is 1 while the current core is not full. `blk_we` and `mem_rd_en` are 0. Every thread context is empty, and its next block is flagged to start from the initial values.
- R2: For a request of length L at offset O for thread T, the formatter issues exactly L reads to thread T. The addresses are O, O+1, ... modulo the memory size, in that order. No two reads occur on consecutive cycles.
- R3: Bytes are packed big-endian: the byte taken first for a block lands in bits 31:24 of word 0, and the 64th in bits 7:0 of word 15.
- R4: A block is written as 16 consecutive cycles with `blk_word_idx` running 0 to 15, and `blk_last` is high on word 15. A block is emitted as soon as a thread's pending count reaches 64 bytes.
- R5: A request without the close flag leaves its unfilled bytes pending for its thread. A later request for the same thread continues that block, even if other threads' requests come in between.
- R6: Closing a context writes 0x80 right after the last message byte and zero bytes after it. Words 14 and 15 of the final block hold the total message length in bits, high half in word 14.
- R7: If more than 55 bytes are pending when a context closes, the formatter emits the marker block without a length field. It then emits an extra block of zeros that carries only the length field.
- R8: `blk_use_iv` is 1 on the first block of each context and 0 on every later block of it.
- R9: Successive blocks go to cores 0, 1, ..., NCORES-1, 0, ... and advance after every block of any thread.
- R10: While the current core's `core_full` is high, `req_ready` is 0 and no block starts. A block that has started is finished regardless of `core_full`.
- R11: A request with the open flag discards whatever the thread had pending and restarts its length total from zero.
- R12: A close request of length zero on an empty context yields one block: 0x80 in bits 31:24 of word 0, and zeros everywhere else, including a zero length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_thread | input | TW | Thread whose memory and context are used |
| req_offset | input | AW | Start byte offset in the thread memory |
| req_len | input | AW+1 | Number of bytes to append (0 to MEM_BYTES) |
| req_open | input | 1 | Start a fresh context before appending |
| req_close | input | 1 | Pad and finish the context after appending |
| mem_rd_en | output | 1 | Byte read strobe |
| mem_rd_thread | output | TW | Thread memory selected |
| mem_rd_addr | output | AW | Byte address |
| mem_rd_data | input | 8 | Byte returned one cycle after the strobe |
| core_full | input | NCORES | Per-core input buffer full |
| blk_we | output | 1 | Block word valid |
| blk_core | output | CW | Destination core |
| blk_word_idx | output | 4 | Word position within the block |
| blk_word | output | 32 | Block word |
| blk_use_iv | output | 1 | Core starts from standard initial values |
| blk_last | output | 1 | Final word of the block |

## Verification
The properties assume three things about the memory and the cores. The memory returns the addressed byte exactly one cycle after each strobe. A core that lowers `core_full` can take a whole 16-word block, whatever it signals afterwards. Request fields are held steady while `req_valid` waits for `req_ready`. The bench keeps to these assumptions. Its memory model is a registered array read, it drives requests only at falling edges and keeps them steady until accepted, and it raises `core_full` only before a block begins. Messages stay well below the 16-bit byte-total limit, so the length field never wraps.

// File: rtl/hbf_pkg.sv
package hbf_pkg;

    localparam int BLK_BYTES  = 64;
    localparam int BLK_WORDS  = 16;
    // Largest pending count (before the marker) that still leaves room for the length field.
    localparam int LEN_ROOM   = BLK_BYTES - 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_WAIT,
        ST_EMIT
    } fmt_state_e;

    // What the block being emitted contains beyond data bytes.
    typedef enum logic [1:0] {
        EK_DATA,     // full block of message bytes
        EK_MARK,     // bytes + 0x80 + zeros, length follows in another block
        EK_MARKLEN,  // bytes + 0x80 + zeros + length
        EK_LEN       // zeros + length only
    } emit_kind_e;

    typedef enum logic [2:0] {
        MOP_NONE,
        MOP_INIT,
        MOP_APPEND,
        MOP_BLOCK,
        MOP_CLOSE
    } meta_op_e;

    function automatic logic kind_has_marker(emit_kind_e k);
        return (k == EK_MARK) || (k == EK_MARKLEN);
    endfunction

    function automatic logic kind_has_len(emit_kind_e k);
        return (k == EK_MARKLEN) || (k == EK_LEN);
    endfunction

endpackage

// File: rtl/hbf_ctx_store.sv
module hbf_ctx_store
    import hbf_pkg::*;
#(
    parameter int NTHREADS = 12,
    parameter int TW       = 4,
    parameter int TOT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  meta_op_e         op,
    input  logic [TW-1:0]    sel_thread,
    input  logic [7:0]       app_byte,
    input  logic [3:0]       word_idx,
    output logic [31:0]      word_raw,
    output logic [6:0]       cnt,
    output logic [TOT_W-1:0] total,
    output logic             fresh
);

    // Pending block bytes, resident per thread; masked by count when read.
    logic [7:0]       data_q [NTHREADS][BLK_BYTES];
    logic [6:0]       cnt_v  [NTHREADS];
    logic [TOT_W-1:0] tot_v  [NTHREADS];
    logic             frs_v  [NTHREADS];
    logic [5:0]       wbase;

    always_ff @(posedge clk) begin
        if (op == MOP_APPEND) begin
            data_q[sel_thread][cnt[5:0]] <= app_byte;
        end
    end

    for (genvar t = 0; t < NTHREADS; t++) begin : g_meta
        logic [6:0]       c_q;
        logic [TOT_W-1:0] n_q;
        logic             f_q;
        logic             hit;

        assign hit = (sel_thread == TW'(t));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c_q <= '0;
                n_q <= '0;
                f_q <= 1'b1;
            end else if (hit) begin
                unique case (op)
                    MOP_INIT, MOP_CLOSE: begin
                        c_q <= '0;
                        n_q <= '0;
                        f_q <= 1'b1;
                    end
                    MOP_APPEND: begin
                        c_q <= c_q + 7'd1;
                        n_q <= n_q + TOT_W'(1);
                    end
                    MOP_BLOCK: begin
                        c_q <= '0;
                        f_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end

        assign cnt_v[t] = c_q;
        assign tot_v[t] = n_q;
        assign frs_v[t] = f_q;
    end

    assign cnt   = cnt_v[sel_thread];
    assign total = tot_v[sel_thread];
    assign fresh = frs_v[sel_thread];

    assign wbase    = {word_idx, 2'b00};
    assign word_raw = {data_q[sel_thread][wbase],
                       data_q[sel_thread][wbase + 6'd1],
                       data_q[sel_thread][wbase + 6'd2],
                       data_q[sel_thread][wbase + 6'd3]};

endmodule

// File: rtl/hbf_word_build.sv
module hbf_word_build
    import hbf_pkg::*;
#(
    parameter int TOT_W = 16
) (
    input  logic [31:0]      word_raw,
    input  logic [3:0]       word_idx,
    input  logic [6:0]       cnt,
    input  emit_kind_e       kind,
    input  logic [TOT_W-1:0] total,
    output logic [31:0]      word_out
);

    logic [63:0] tot_ext;
    logic [63:0] bitlen;
    logic [31:0] lanes;

    assign tot_ext = 64'(total);
    assign bitlen  = {tot_ext[60:0], 3'b000};

    // Each byte lane picks data, the terminator, or zero by its position in the block.
    for (genvar b = 0; b < 4; b++) begin : g_lane
        logic [6:0] pos;
        logic [7:0] lane_b;

        assign pos = {1'b0, word_idx, 2'(b)};

        always_comb begin
            if (pos < cnt) begin
                lane_b = word_raw[31-8*b -: 8];
            end else if (kind_has_marker(kind) && (pos == cnt)) begin
                lane_b = 8'h80;
            end else begin
                lane_b = 8'h00;
            end
        end

        assign lanes[31-8*b -: 8] = lane_b;
    end

    always_comb begin
        if (kind_has_len(kind) && (word_idx == 4'd14)) begin
            word_out = bitlen[63:32];
        end else if (kind_has_len(kind) && (word_idx == 4'd15)) begin
            word_out = bitlen[31:0];
        end else begin
            word_out = lanes;
        end
    end

endmodule

// File: rtl/hbf_core_rotor.sv
module hbf_core_rotor #(
    parameter int NCORES = 3,
    parameter int CW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [CW-1:0] core_idx
);

    if (NCORES == 1) begin : g_single
        assign core_idx = '0;
    end else begin : g_multi
        logic [CW-1:0] idx_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                idx_q <= '0;
            end else if (advance) begin
                idx_q <= (idx_q == CW'(NCORES - 1)) ? '0 : idx_q + CW'(1);
            end
        end

        assign core_idx = idx_q;
    end

endmodule

// File: rtl/hash_block_formatter.sv
module hash_block_formatter
    import hbf_pkg::*;
#(
    parameter int NTHREADS  = 12,
    parameter int MEM_BYTES = 128,
    parameter int NCORES    = 3,
    parameter int TOT_W     = 16,
    localparam int TW = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int LW = AW + 1,
    localparam int CW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TW-1:0]     req_thread,
    input  logic [AW-1:0]     req_offset,
    input  logic [LW-1:0]     req_len,
    input  logic              req_open,
    input  logic              req_close,
    output logic              mem_rd_en,
    output logic [TW-1:0]     mem_rd_thread,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    input  logic [NCORES-1:0] core_full,
    output logic              blk_we,
    output logic [CW-1:0]     blk_core,
    output logic [3:0]        blk_word_idx,
    output logic [31:0]       blk_word,
    output logic              blk_use_iv,
    output logic              blk_last
);

    fmt_state_e        state_q, state_d;
    emit_kind_e        kind_q, kind_d;
    logic [TW-1:0]     thr_q, thr_d;
    logic [AW-1:0]     addr_q, addr_d;
    logic [LW-1:0]     remain_q, remain_d;
    logic              close_q, close_d;
    logic [3:0]        widx_q, widx_d;

    meta_op_e          mop;
    logic [TW-1:0]     ctx_thread;
    logic [31:0]       raw_word;
    logic [6:0]        ctx_cnt;
    logic [TOT_W-1:0]  ctx_total;
    logic              ctx_fresh;
    logic [CW-1:0]     core_idx;
    logic              tgt_full;
    logic              accept;
    logic              blk_end;
    logic [31:0]       built_word;

    assign tgt_full = core_full[core_idx];
    assign accept   = req_valid && req_ready;
    assign blk_end  = (state_q == ST_EMIT) && (widx_q == 4'd15);

    // State and datapath register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            kind_q   <= EK_DATA;
            thr_q    <= '0;
            addr_q   <= '0;
            remain_q <= '0;
            close_q  <= 1'b0;
            widx_q   <= '0;
        end else begin
            state_q  <= state_d;
            kind_q   <= kind_d;
            thr_q    <= thr_d;
            addr_q   <= addr_d;
            remain_q <= remain_d;
            close_q  <= close_d;
            widx_q   <= widx_d;
        end
    end

    // Transitions
    always_comb begin
        state_d  = state_q;
        kind_d   = kind_q;
        thr_d    = thr_q;
        addr_d   = addr_q;
        remain_d = remain_q;
        close_d  = close_q;
        widx_d   = widx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    thr_d    = req_thread;
                    addr_d   = req_offset;
                    remain_d = req_len;
                    close_d  = req_close;
                    state_d  = ST_READ;
                end
            end
            ST_READ: begin
                if (remain_q != '0) begin
                    addr_d  = addr_q + AW'(1);
                    state_d = ST_WRITE;
                end else if (close_q) begin
                    kind_d  = (ctx_cnt <= 7'(LEN_ROOM)) ? EK_MARKLEN : EK_MARK;
                    state_d = ST_WAIT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WRITE: begin
                remain_d = remain_q - LW'(1);
                if (ctx_cnt == 7'(BLK_BYTES - 1)) begin
                    kind_d  = EK_DATA;
                    state_d = ST_WAIT;
                end else begin
                    state_d = ST_READ;
                end
            end
            ST_WAIT: begin
                if (!tgt_full) begin
                    widx_d  = '0;
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                widx_d = widx_q + 4'd1;
                if (widx_q == 4'd15) begin
                    unique case (kind_q)
                        EK_DATA: state_d = ST_READ;
                        EK_MARK: begin
                            kind_d  = EK_LEN;
                            state_d = ST_WAIT;
                        end
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and context commands
    always_comb begin
        req_ready     = (state_q == ST_IDLE) && !tgt_full;
        mem_rd_en     = (state_q == ST_READ) && (remain_q != '0);
        mem_rd_thread = thr_q;
        mem_rd_addr   = addr_q;
        blk_we        = (state_q == ST_EMIT);
        blk_core      = core_idx;
        blk_word_idx  = widx_q;
        blk_word      = built_word;
        blk_use_iv    = ctx_fresh;
        blk_last      = blk_end;
        ctx_thread    = (state_q == ST_IDLE) ? req_thread : thr_q;
        mop           = MOP_NONE;
        unique case (state_q)
            ST_IDLE:  if (accept && req_open) mop = MOP_INIT;
            ST_WRITE: mop = MOP_APPEND;
            ST_EMIT: begin
                if (widx_q == 4'd15) begin
                    mop = ((kind_q == EK_DATA) || (kind_q == EK_MARK)) ? MOP_BLOCK : MOP_CLOSE;
                end
            end
            default: mop = MOP_NONE;
        endcase
    end

    hbf_ctx_store #(
        .NTHREADS (NTHREADS),
        .TW       (TW),
        .TOT_W    (TOT_W)
    ) u_ctx (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (mop),
        .sel_thread (ctx_thread),
        .app_byte   (mem_rd_data),
        .word_idx   (widx_q),
        .word_raw   (raw_word),
        .cnt        (ctx_cnt),
        .total      (ctx_total),
        .fresh      (ctx_fresh)
    );

    hbf_word_build #(
        .TOT_W (TOT_W)
    ) u_build (
        .word_raw (raw_word),
        .word_idx (widx_q),
        .cnt      (ctx_cnt),
        .kind     (kind_q),
        .total    (ctx_total),
        .word_out (built_word)
    );

    hbf_core_rotor #(
        .NCORES (NCORES),
        .CW     (CW)
    ) u_rotor (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (blk_end),
        .core_idx (core_idx)
    );

endmodule

// File: rtl/hbf_checker.sv
module hbf_checker #(
    parameter int NCORES = 3,
    parameter int CW     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCORES-1:0] core_full,
    input logic              req_ready,
    input logic              mem_rd_en,
    input logic              blk_we,
    input logic [CW-1:0]     blk_core,
    input logic [3:0]        blk_word_idx,
    input logic              blk_last
);

    logic [NCORES-1:0] full_d;
    logic [CW-1:0]     exp_core_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_d     <= '0;
            exp_core_q <= '0;
        end else begin
            full_d <= core_full;
            if (blk_we && blk_last) begin
                exp_core_q <= (exp_core_q == CW'(NCORES - 1)) ? '0 : exp_core_q + CW'(1);
            end
        end
    end

    assert_rd_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    assert_block_opens_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_we) |-> (blk_word_idx == 4'd0));

    assert_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_we && !blk_last) |=> (blk_we && (blk_word_idx == $past(blk_word_idx) + 4'd1)));

    assert_core_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        blk_we |-> (blk_core == exp_core_q));

    assert_no_start_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_we && (blk_word_idx == 4'd0)) |-> !full_d[blk_core]);

    assert_core_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_we && !blk_last) |=> $stable(blk_core));

    assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!blk_we && !mem_rd_en));

endmodule

bind hash_block_formatter hbf_checker #(
    .NCORES (NCORES),
    .CW     (CW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_full    (core_full),
    .req_ready    (req_ready),
    .mem_rd_en    (mem_rd_en),
    .blk_we       (blk_we),
    .blk_core     (blk_core),
    .blk_word_idx (blk_word_idx),
    .blk_last     (blk_last)
);

// File: tb/sim_hash_block_formatter.sv
`timescale 1ns/1ps
module sim_hash_block_formatter;

    localparam int NTHR = 12;
    localparam int MEMB = 128;
    localparam int NC   = 3;
    localparam int TOTW = 16;
    localparam int TW   = 4;
    localparam int AW   = 7;
    localparam int CW   = 2;
    localparam int MAXB = 64;

    // thread, offset, length, open, close, expected block count
    localparam int NROWS = 9;
    localparam int TBL [NROWS][6] = '{
        '{0,   0,  64, 1, 0, 1},
        '{0,  10,   3, 0, 1, 1},
        '{1,  20,  50, 1, 0, 0},
        '{2, 120,  16, 1, 0, 0},
        '{1,   0,  20, 0, 0, 1},
        '{2,   5,  40, 0, 1, 2},
        '{1, 100,   0, 0, 1, 1},
        '{3,   0, 128, 1, 1, 3},
        '{11,  7,  55, 1, 1, 1}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            req_valid;
    logic            req_ready;
    logic [TW-1:0]   req_thread;
    logic [AW-1:0]   req_offset;
    logic [AW:0]     req_len;
    logic            req_open;
    logic            req_close;
    logic            mem_rd_en;
    logic [TW-1:0]   mem_rd_thread;
    logic [AW-1:0]   mem_rd_addr;
    logic [7:0]      mem_rd_data;
    logic [NC-1:0]   core_full;
    logic            blk_we;
    logic [CW-1:0]   blk_core;
    logic [3:0]      blk_word_idx;
    logic [31:0]     blk_word;
    logic            blk_use_iv;
    logic            blk_last;

    always #2.5 clk = ~clk;

    hash_block_formatter #(
        .NTHREADS (NTHR), .MEM_BYTES (MEMB), .NCORES (NC), .TOT_W (TOTW)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_thread (req_thread),
        .req_offset (req_offset), .req_len (req_len), .req_open (req_open),
        .req_close (req_close),
        .mem_rd_en (mem_rd_en), .mem_rd_thread (mem_rd_thread),
        .mem_rd_addr (mem_rd_addr), .mem_rd_data (mem_rd_data),
        .core_full (core_full),
        .blk_we (blk_we), .blk_core (blk_core), .blk_word_idx (blk_word_idx),
        .blk_word (blk_word), .blk_use_iv (blk_use_iv), .blk_last (blk_last)
    );

    function automatic logic [7:0] mem_val(int t, int a);
        return 8'(t * 37 + a * 5 + 1);
    endfunction

    // Thread memories: registered read, one cycle latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem_val(int'(mem_rd_thread), int'(mem_rd_addr));
    end

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Read monitor
    int exp_rd_thr;
    int exp_rd_addr;
    int rd_count;
    bit rd_bad;
    always @(negedge clk) begin
        if (rst_n && mem_rd_en) begin
            if (int'(mem_rd_thread) != exp_rd_thr || int'(mem_rd_addr) != (exp_rd_addr % MEMB))
                rd_bad = 1'b1;
            exp_rd_addr++;
            rd_count++;
        end
    end

    // Block capture
    logic [31:0] cap_w    [MAXB][16];
    int          cap_core [MAXB];
    bit          cap_iv   [MAXB];
    int          cap_n = 0;
    always @(negedge clk) begin
        if (rst_n && blk_we && cap_n < MAXB) begin
            cap_w[cap_n][blk_word_idx] = blk_word;
            if (blk_word_idx == 4'd0) begin
                cap_core[cap_n] = int'(blk_core);
                cap_iv[cap_n]   = blk_use_iv;
            end
            if (blk_last) cap_n++;
        end
    end

    // Reference model of the requirements
    logic [7:0]  m_buf   [NTHR][64];
    int          m_cnt   [NTHR];
    longint      m_tot   [NTHR];
    bit          m_fresh [NTHR];
    int          m_core = 0;
    logic [31:0] exp_w    [MAXB][16];
    int          exp_core [MAXB];
    bit          exp_iv   [MAXB];
    string       exp_tag  [MAXB];
    int          exp_n = 0;

    task automatic m_emit(int t, string tag);
        for (int w = 0; w < 16; w++)
            exp_w[exp_n][w] = {m_buf[t][4*w], m_buf[t][4*w+1], m_buf[t][4*w+2], m_buf[t][4*w+3]};
        exp_core[exp_n] = m_core;
        m_core = (m_core + 1) % NC;
        exp_iv[exp_n] = m_fresh[t];
        m_fresh[t] = 1'b0;
        exp_tag[exp_n] = tag;
        exp_n++;
    endtask

    task automatic m_request(int t, int off, int len, bit open, bit close);
        bit resumed;
        longint bits;
        if (open) begin
            m_cnt[t] = 0; m_tot[t] = 0; m_fresh[t] = 1'b1;
        end
        resumed = (m_cnt[t] > 0);
        for (int i = 0; i < len; i++) begin
            m_buf[t][m_cnt[t]] = mem_val(t, (off + i) % MEMB);
            m_cnt[t]++;
            m_tot[t]++;
            if (m_cnt[t] == 64) begin
                m_emit(t, resumed ? "R5" : "R3");
                m_cnt[t] = 0;
            end
        end
        if (close) begin
            m_buf[t][m_cnt[t]] = 8'h80;
            m_cnt[t]++;
            for (int k = m_cnt[t]; k < 64; k++) m_buf[t][k] = 8'h00;
            if (m_cnt[t] > 56) begin
                m_emit(t, "R7");
                for (int k = 0; k < 64; k++) m_buf[t][k] = 8'h00;
            end
            bits = m_tot[t] * 8;
            for (int k = 0; k < 8; k++) m_buf[t][56 + k] = 8'(bits >> (8 * (7 - k)));
            m_emit(t, "R6");
            m_cnt[t] = 0; m_tot[t] = 0; m_fresh[t] = 1'b1;
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!req_ready);
    endtask

    task automatic arm_reads(int t, int off);
        exp_rd_thr  = t;
        exp_rd_addr = off;
        rd_count    = 0;
        rd_bad      = 1'b0;
    endtask

    task automatic drive_req(int t, int off, int len, bit open, bit close);
        arm_reads(t, off);
        m_request(t, off, len, open, close);
        req_valid  = 1'b1;
        req_thread = TW'(t);
        req_offset = AW'(off);
        req_len    = (AW+1)'(len);
        req_open   = open;
        req_close  = close;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        check(rd_count == len && !rd_bad, "R2", "read count/address order", rd_count, len);
    endtask

    task automatic compare_new(string override, int first, int nexp);
        string tag;
        int bad_w;
        check(cap_n - first == nexp, "R4", "blocks emitted", cap_n - first, nexp);
        for (int b = first; b < exp_n && b < cap_n; b++) begin
            tag = (override != "") ? override : exp_tag[b];
            bad_w = -1;
            for (int w = 15; w >= 0; w--)
                if (cap_w[b][w] !== exp_w[b][w]) bad_w = w;
            if (bad_w < 0)
                check(1'b1, tag, "block words", 0, 0);
            else
                check(1'b0, tag, $sformatf("block %0d word %0d", b, bad_w),
                      cap_w[b][bad_w], exp_w[b][bad_w]);
            check(cap_iv[b] == exp_iv[b], "R8", $sformatf("block %0d use_iv", b),
                  cap_iv[b], exp_iv[b]);
            check(cap_core[b] == exp_core[b], "R9", $sformatf("block %0d core", b),
                  cap_core[b], exp_core[b]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int first;
        for (int t = 0; t < NTHR; t++) begin
            m_cnt[t] = 0; m_tot[t] = 0; m_fresh[t] = 1'b1;
            for (int k = 0; k < 64; k++) m_buf[t][k] = 8'h00;
        end
        rst_n = 1'b0; req_valid = 1'b0; req_thread = '0; req_offset = '0;
        req_len = '0; req_open = 1'b0; req_close = 1'b0; core_full = '0;
        arm_reads(0, 0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(blk_we == 1'b0 && mem_rd_en == 1'b0, "R1", "idle strobes after reset",
              {blk_we, mem_rd_en}, 0);

        // Table of requests
        for (int r = 0; r < NROWS; r++) begin
            first = cap_n;
            drive_req(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3] != 0, TBL[r][4] != 0);
            compare_new("", first, TBL[r][5]);
        end

        // R11: open discards pending bytes
        first = cap_n;
        drive_req(4, 0, 30, 1'b1, 1'b0);
        compare_new("R11", first, 0);
        first = cap_n;
        drive_req(4, 3, 5, 1'b1, 1'b1);
        compare_new("R11", first, 1);

        // R12: empty close
        first = cap_n;
        drive_req(5, 60, 0, 1'b1, 1'b1);
        compare_new("R12", first, 1);
        check(cap_w[first][0] == 32'h8000_0000, "R12", "marker word", cap_w[first][0], 32'h8000_0000);

        // R10: back-pressure from the cores
        first = cap_n;
        arm_reads(6, 0);
        m_request(6, 0, 64, 1'b1, 1'b0);
        core_full  = '1;
        req_valid  = 1'b1; req_thread = TW'(6); req_offset = '0;
        req_len    = (AW+1)'(64); req_open = 1'b1; req_close = 1'b0;
        repeat (5) @(negedge clk);
        check(req_ready == 1'b0 && mem_rd_en == 1'b0, "R10", "request held while core full",
              req_ready, 0);
        core_full = '0;
        @(negedge clk);
        req_valid = 1'b0;
        core_full = '1;
        repeat (150) @(negedge clk);
        check(cap_n == first && blk_we == 1'b0, "R10", "no block while core full", cap_n - first, 0);
        core_full = '0;
        wait_idle();
        check(rd_count == 64 && !rd_bad, "R2", "read count under stall", rd_count, 64);
        compare_new("R10", first, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule